// File: doc/BRIEF.md
# PHY-side link interface sequencer

This block sits on the physical-layer side of the parallel interface between a serial-bus PHY and its link controller. It drives the two control lines and the eight data lines in the local system clock domain. It sequences four kinds of activity on those lines: idle, status reporting, packet reception and bus grant. After a grant it hands the lines over to the link for transmission and tracks when the link gives them back. Its inputs are abstract events from the rest of the PHY: a status word that is pending, a receive start with its speed code, a byte stream paced by a ready signal, a packet end, and an arbitration win.

The block also watches the link-power-status input. When that input stays low for longer than a programmable number of clock cycles, the block forces a low-power reset of the interface. In that state every output is held at zero and requests from the link are ignored. The first high sample of the input releases the interface into idle.

Top module: `phy_link_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ctl_o` is 00, `d_o` is 00h, and `link_owns` and `rx_ready` are 0.
- R2: A status transfer starts only from idle. It drives `ctl_o`=01 for STAT_W/2 cycles. In each of those cycles `d_o[1:0]` carries the next pair of the status word, most significant pair first, and `d_o[7:2]` is 0. At least one idle cycle (`ctl_o`=00) follows.
- R3: A status or arbitration event that arrives while the interface is busy is held pending. It is served only after the interface has returned to idle.
- R4: An arbitration win drives `ctl_o`=11 for exactly one cycle and then 00 for one cycle. After that `link_owns` is 1, and while `link_owns` is 1 both `ctl_o` and `d_o` are 0.
- R5: The link's control code 00 means idle and any other value means active. If the link's first two sampled codes are both idle, ownership ends after the second one. Once the link has driven a non-idle code, ownership ends at its first idle code. An idle cycle then follows on `ctl_o`.
- R6: A receive starts with one cycle of `ctl_o`=10 and `d_o`=FFh. The next cycle carries `ctl_o`=10 and `d_o`={6'b0, speed}.
- R7: Receive bytes are delivered according to the speed code. Speed 0 gives four beats of two bits on `d_o[1:0]`. Speed 1 gives two beats of four bits on `d_o[3:0]`. Speeds 2 and 3 give one full byte per beat. In every case the most significant part comes first and the unused data lines are 0.
- R8: `rx_ready` is 1 in the speed-code cycle and in the last beat of each byte. If neither `rx_valid` nor `rx_end` is presented then, the block drives `ctl_o`=10 with `d_o`=FFh and stays ready. `rx_end` returns the lines to idle.
- R9: A receive start during a status transfer switches `ctl_o` from 01 straight to 10 with no idle cycle between. The interrupted status is dropped.
- R10: When several events arrive together in idle, a receive start wins over an arbitration win, and an arbitration win wins over pending status.
- R11: After more than LPS_LIM consecutive low samples of `lps_in`, the block clamps the interface. `ctl_o`, `d_o`, `link_owns`, `rx_ready` and `lreq_fwd` are then 0, any transfer in progress is abandoned, and pending events are discarded. Exactly LPS_LIM low samples do not clamp.
- R12: The first high sample of `lps_in` releases the clamp in the next cycle. Status and arbitration events presented during the clamp have no effect after release.
- R13: `lreq_fwd` follows `lreq_in` whenever the interface is not clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lps_in | input | 1 | Link power status from the link controller |
| lreq_in | input | 1 | Serial request line from the link |
| lreq_fwd | output | 1 | Request line passed on to the PHY core, gated by the clamp |
| stat_pend | input | 1 | Pulse: a status word is waiting to be reported |
| stat_word | input | STAT_W | Status bits to report |
| arb_won | input | 1 | Pulse: the PHY has won bus arbitration |
| rx_start | input | 1 | Pulse: a packet receive is beginning |
| rx_speed | input | 2 | Speed code of the received packet |
| rx_valid | input | 1 | A receive byte is offered on rx_byte |
| rx_byte | input | 8 | Receive byte |
| rx_end | input | 1 | The received packet has ended |
| rx_ready | output | 1 | The block takes a byte or an end marker in this cycle |
| link_ctl | input | 2 | Control code the link drives while it owns the lines |
| ctl_o | output | 2 | Control lines toward the link (00 idle, 01 status, 10 receive, 11 grant) |
| d_o | output | 8 | Data lines toward the link |
| link_owns | output | 1 | The link currently owns the control and data lines |

## Verification
The bench builds the block with an eight-bit status word and a power threshold of six cycles. With these values every one of the 256 status words can be reported, and every byte value can be sent at every speed code, within a short run. The small threshold puts both sides of the clamp boundary a few cycles apart, so the bench can check exactly six low samples and exactly seven, from inside a stalled receive. Directed sequences then cover preemption, priority among simultaneous events, both ways the link can give the lines back, and requests that are dropped during the clamp.

// File: rtl/phy_link_pkg.sv
package phy_link_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE  = 2'b00,
    CTL_STAT  = 2'b01,
    CTL_RECV  = 2'b10,
    CTL_GRANT = 2'b11
  } ctl_e;

  typedef enum logic [3:0] {
    S_IDLE, S_POST, S_STAT, S_GRANT, S_GAP, S_LINK,
    S_RXON, S_RXSPD, S_RXGAP, S_RXDAT
  } seq_e;

  localparam logic [7:0] DATA_ON = 8'hFF;

  // number of clock beats needed to deliver one byte at a given speed
  function automatic logic [2:0] beats_for(input logic [1:0] spd);
    case (spd)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] speed_word(input logic [1:0] spd);
    return {6'b0, spd};
  endfunction

  // slice of a byte shown on the data lines at a given beat
  function automatic logic [7:0] lane_chunk(input logic [7:0] b, input logic [1:0] spd,
                                            input logic [1:0] beat);
    logic [7:0] sh;
    case (spd)
      2'd0: begin
        sh = b << {beat, 1'b0};
        return {6'b0, sh[7:6]};
      end
      2'd1: begin
        sh = b << {beat[0], 2'b00};
        return {4'b0, sh[7:4]};
      end
      default: return b;
    endcase
  endfunction

endpackage

// File: rtl/phy_lps_watch.sv
module phy_lps_watch #(
  parameter int LIM = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps,
  output logic pwr_off
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIM);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pwr_off <= 1'b0;
    end else if (lps) begin
      cnt_q   <= '0;
      pwr_off <= 1'b0;
    end else if (cnt_q == LIM_C) begin
      pwr_off <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/phy_rx_lane.sv
module phy_rx_lane
  import phy_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spd_ld,
  input  logic [1:0] spd_in,
  input  logic       byte_ld,
  input  logic [7:0] byte_in,
  input  logic       step,
  output logic [7:0] spd_word,
  output logic [7:0] chunk,
  output logic       last
);
  logic [1:0] spd_q;
  logic [7:0] byte_q;
  logic [1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spd_q  <= '0;
      byte_q <= '0;
      beat_q <= '0;
    end else begin
      if (spd_ld) spd_q <= spd_in;
      if (byte_ld) begin
        byte_q <= byte_in;
        beat_q <= '0;
      end else if (step) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign spd_word = speed_word(spd_q);
  assign chunk    = lane_chunk(byte_q, spd_q, beat_q);
  assign last     = ({1'b0, beat_q} == (beats_for(spd_q) - 3'd1));
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_pkg::*;
#(
  parameter int STAT_W  = 16,
  parameter int LPS_LIM = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lps_in,
  input  logic              lreq_in,
  output logic              lreq_fwd,
  input  logic              stat_pend,
  input  logic [STAT_W-1:0] stat_word,
  input  logic              arb_won,
  input  logic              rx_start,
  input  logic [1:0]        rx_speed,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_end,
  output logic              rx_ready,
  input  logic [1:0]        link_ctl,
  output logic [1:0]        ctl_o,
  output logic [7:0]        d_o,
  output logic              link_owns
);
  localparam int SB  = STAT_W / 2;
  localparam int SCW = (SB > 1) ? $clog2(SB) : 1;
  localparam logic [SCW-1:0] SB_LAST = SCW'(SB - 1);

  seq_e              st_q, st_n;
  logic [STAT_W-1:0] sr_q;
  logic [SCW-1:0]    scnt_q;
  logic              stat_q, arb_q, lk_act_q, lk_idle_q;

  // named internal events
  logic pwr_off, lane_last, rx_rdy_int, rx_take;
  logic stat_want, arb_want, rx_go, gr_go, st_go;
  logic [7:0] lane_spd, lane_chunk_w;

  phy_lps_watch #(.LIM(LPS_LIM)) u_watch (
    .clk(clk), .rst_n(rst_n), .lps(lps_in), .pwr_off(pwr_off)
  );

  assign rx_rdy_int = (st_q == S_RXSPD) || (st_q == S_RXGAP) ||
                      ((st_q == S_RXDAT) && lane_last);
  assign rx_take    = rx_rdy_int && rx_valid;
  assign stat_want  = stat_q | stat_pend;
  assign arb_want   = arb_q | arb_won;
  assign rx_go      = rx_start && ((st_q == S_IDLE) || (st_q == S_POST) || (st_q == S_STAT));
  assign gr_go      = (st_q == S_IDLE) && !rx_start && arb_want;
  assign st_go      = (st_q == S_IDLE) && !rx_start && !arb_want && stat_want;

  phy_rx_lane u_lane (
    .clk(clk), .rst_n(rst_n),
    .spd_ld(rx_go && !pwr_off), .spd_in(rx_speed),
    .byte_ld(rx_take && !pwr_off), .byte_in(rx_byte),
    .step((st_q == S_RXDAT) && !lane_last),
    .spd_word(lane_spd), .chunk(lane_chunk_w), .last(lane_last)
  );

  always_comb begin
    st_n = st_q;
    case (st_q)
      S_IDLE:  if (rx_go) st_n = S_RXON;
               else if (gr_go) st_n = S_GRANT;
               else if (st_go) st_n = S_STAT;
      S_POST:  st_n = rx_go ? S_RXON : S_IDLE;
      S_STAT:  if (rx_go) st_n = S_RXON;
               else if (scnt_q == SB_LAST) st_n = S_POST;
      S_GRANT: st_n = S_GAP;
      S_GAP:   st_n = S_LINK;
      S_LINK:  if (link_ctl == 2'b00 && (lk_act_q || lk_idle_q)) st_n = S_POST;
      S_RXON:  st_n = S_RXSPD;
      S_RXSPD, S_RXGAP, S_RXDAT:
        if (rx_rdy_int) begin
          if (rx_valid)    st_n = S_RXDAT;
          else if (rx_end) st_n = S_POST;
          else             st_n = S_RXGAP;
        end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_off) begin
      st_q      <= S_IDLE;
      sr_q      <= '0;
      scnt_q    <= '0;
      stat_q    <= 1'b0;
      arb_q     <= 1'b0;
      lk_act_q  <= 1'b0;
      lk_idle_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      stat_q <= stat_want && !st_go;
      arb_q  <= arb_want && !gr_go;
      if (st_go) begin
        sr_q   <= stat_word;
        scnt_q <= '0;
      end else if (st_q == S_STAT) begin
        sr_q   <= sr_q << 2;
        scnt_q <= scnt_q + 1'b1;
      end
      if (st_q == S_GAP) begin
        lk_act_q  <= 1'b0;
        lk_idle_q <= 1'b0;
      end else if (st_q == S_LINK) begin
        if (link_ctl != 2'b00) lk_act_q <= 1'b1;
        else                   lk_idle_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl_o = CTL_IDLE;
    d_o   = 8'h00;
    case (st_q)
      S_STAT:  begin ctl_o = CTL_STAT;  d_o = {6'b0, sr_q[STAT_W-1 -: 2]}; end
      S_GRANT: ctl_o = CTL_GRANT;
      S_RXON, S_RXGAP: begin ctl_o = CTL_RECV; d_o = DATA_ON; end
      S_RXSPD: begin ctl_o = CTL_RECV; d_o = lane_spd; end
      S_RXDAT: begin ctl_o = CTL_RECV; d_o = lane_chunk_w; end
      default: ;
    endcase
    if (pwr_off) begin
      ctl_o = CTL_IDLE;
      d_o   = 8'h00;
    end
  end

  assign link_owns = (st_q == S_LINK) && !pwr_off;
  assign rx_ready  = rx_rdy_int && !pwr_off;
  assign lreq_fwd  = lreq_in && !pwr_off;
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk #(
  parameter int LIM = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lps_in,
  input logic [1:0] ctl_o,
  input logic [7:0] d_o,
  input logic       link_owns,
  input logic       lreq_fwd,
  input logic       rx_ready,
  input logic       pwr_off
);
  localparam int CW = $clog2(LIM + 2);
  localparam logic [CW-1:0] TOP = CW'(LIM + 1);

  logic [CW-1:0] lo_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || lps_in) lo_cnt <= '0;
    else if (lo_cnt != TOP) lo_cnt <= lo_cnt + 1'b1;
  end

  AST_CLAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> (ctl_o == 2'b00 && d_o == 8'h00 && !link_owns && !lreq_fwd && !rx_ready)); // R11
  AST_LPS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off == (lo_cnt == TOP)); // R11
  AST_LPS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lps_in) |-> !pwr_off); // R12
  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n || pwr_off)
    (ctl_o == 2'b11) |=> (ctl_o == 2'b00 && !link_owns)); // R4
  AST_GRANT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n || pwr_off)
    (ctl_o == 2'b00 && $past(ctl_o) == 2'b11) |=> link_owns); // R4
  AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    link_owns |-> (ctl_o == 2'b00 && d_o == 8'h00)); // R4
  AST_STAT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o == 2'b01 && $past(ctl_o) != 2'b01) |-> $past(ctl_o) == 2'b00); // R2
  AST_STAT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o == 2'b01) |-> (d_o[7:2] == 6'b0)); // R2
  AST_RX_DATA_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o == 2'b10 && $past(ctl_o) != 2'b10) |-> d_o == 8'hFF); // R6
endmodule

bind phy_link_seq phy_link_seq_chk #(.LIM(LPS_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .ctl_o(ctl_o), .d_o(d_o),
  .link_owns(link_owns), .lreq_fwd(lreq_fwd), .rx_ready(rx_ready), .pwr_off(pwr_off)
);

// File: tb/phy_link_seq_test.sv
module phy_link_seq_test;
  localparam int SW  = 8;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rst_n, lps_in, lreq_in, lreq_fwd, stat_pend, arb_won, rx_start;
  logic rx_valid, rx_end, rx_ready, link_owns;
  logic [SW-1:0] stat_word;
  logic [1:0] rx_speed, link_ctl, ctl_o;
  logic [7:0] rx_byte, d_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phy_link_seq #(.STAT_W(SW), .LPS_LIM(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .lreq_in(lreq_in), .lreq_fwd(lreq_fwd),
    .stat_pend(stat_pend), .stat_word(stat_word), .arb_won(arb_won),
    .rx_start(rx_start), .rx_speed(rx_speed), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_ready(rx_ready), .link_ctl(link_ctl),
    .ctl_o(ctl_o), .d_o(d_o), .link_owns(link_owns)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rx_packet(input int spd, input int gap_at);
    int nb, bw;
    nb = (spd == 0) ? 4 : (spd == 1) ? 2 : 1;
    bw = 8 / nb;
    rx_start = 1; rx_speed = 2'(spd);
    step();
    rx_start = 0;
    check("R6 data-on ctl", ctl_o, 2'b10);
    check("R6 data-on d", d_o, 8'hFF);
    step();
    check("R6 speed word", d_o, spd);
    check("R8 ready at speed", rx_ready, 1);
    for (int b = 0; b < 256; b++) begin
      rx_valid = 1; rx_byte = 8'(b);
      step();
      rx_valid = 0;
      for (int k = 0; k < nb; k++) begin
        check("R7 chunk", d_o, (b >> (8 - bw * (k + 1))) & ((1 << bw) - 1));
        if (k < nb - 1) step();
      end
      check("R8 ready at last beat", rx_ready, 1);
      if (b == gap_at) begin
        step();
        check("R8 gap ctl", ctl_o, 2'b10);
        check("R8 gap d", d_o, 8'hFF);
        check("R8 gap ready", rx_ready, 1);
      end
    end
    rx_end = 1;
    step();
    rx_end = 0;
    check("R8 end idle", ctl_o, 2'b00);
    step();
  endtask

  initial begin
    rst_n = 0; lps_in = 1; lreq_in = 0; stat_pend = 0; stat_word = '0; arb_won = 0;
    rx_start = 0; rx_speed = 0; rx_valid = 0; rx_byte = 0; rx_end = 0; link_ctl = 0;
    repeat (3) step();
    check("R1 ctl in reset", ctl_o, 0);
    check("R1 owns in reset", link_owns, 0);
    rst_n = 1;
    step();
    check("R1 ctl", ctl_o, 0);
    check("R1 d", d_o, 0);
    check("R1 owns", link_owns, 0);
    check("R1 ready", rx_ready, 0);

    // R2: every status word
    for (int w = 0; w < 256; w++) begin
      stat_pend = 1; stat_word = 8'(w);
      step();
      stat_pend = 0;
      for (int k = 0; k < SW / 2; k++) begin
        check("R2 status ctl", ctl_o, 2'b01);
        check("R2 status pair", d_o, (w >> (SW - 2 - 2 * k)) & 3);
        step();
      end
      check("R2 trailing idle", ctl_o, 2'b00);
      step();
    end

    // R6 R7 R8: every byte at every speed
    for (int s = 0; s < 4; s++) rx_packet(s, 17 + s);

    // R9: receive interrupts status
    stat_pend = 1; stat_word = 8'hB4;
    step();
    stat_pend = 0;
    check("R9 status first pair", d_o, 2);
    step();
    check("R9 status second pair", d_o, 3);
    rx_start = 1; rx_speed = 2;
    step();
    rx_start = 0;
    check("R9 straight to receive", ctl_o, 2'b10);
    check("R9 data-on", d_o, 8'hFF);
    step();
    rx_end = 1;
    step();
    rx_end = 0;
    check("R9 idle after end", ctl_o, 0);
    step(); step();
    check("R9 status dropped", ctl_o, 0);

    // R10 R3 R4 R5: simultaneous events
    rx_start = 1; rx_speed = 0; arb_won = 1; stat_pend = 1; stat_word = 8'hC0;
    step();
    rx_start = 0; arb_won = 0; stat_pend = 0;
    check("R10 receive first", ctl_o, 2'b10);
    step();
    rx_end = 1;
    step();
    rx_end = 0;
    check("R3 post idle", ctl_o, 0);
    step();
    check("R3 idle before pending", ctl_o, 0);
    step();
    check("R10 grant before status", ctl_o, 2'b11);
    check("R4 grant not owned", link_owns, 0);
    step();
    check("R4 idle after grant", ctl_o, 0);
    check("R4 not yet owned", link_owns, 0);
    step();
    check("R4 owned", link_owns, 1);
    check("R4 released d", d_o, 0);
    link_ctl = 2'b01;
    step();
    check("R5 hold keeps", link_owns, 1);
    link_ctl = 2'b10;
    step();
    check("R5 transmit keeps", link_owns, 1);
    link_ctl = 2'b00;
    step();
    check("R5 idle ends", link_owns, 0);
    check("R5 idle ctl", ctl_o, 0);
    step();
    step();
    check("R3 pending status served", ctl_o, 2'b01);
    check("R3 pending status pair", d_o, 3);
    repeat (5) step();

    // R5: link takes no action
    arb_won = 1;
    step();
    arb_won = 0;
    check("R4 grant", ctl_o, 2'b11);
    step(); step();
    check("R5 owned", link_owns, 1);
    step();
    check("R5 one idle allowed", link_owns, 1);
    step();
    check("R5 second idle ends", link_owns, 0);
    step();

    // R5: one idle then hold
    arb_won = 1;
    step();
    arb_won = 0;
    step(); step();
    step();
    check("R5 after optional idle", link_owns, 1);
    link_ctl = 2'b01;
    step();
    check("R5 hold after idle", link_owns, 1);
    link_ctl = 2'b00;
    step();
    check("R5 released", link_owns, 0);
    step();

    // R11 R12 R13: power watchdog during a stalled receive
    rx_start = 1; rx_speed = 1;
    step();
    rx_start = 0;
    step(); step();
    lps_in = 0;
    for (int i = 1; i <= LIM; i++) step();
    check("R11 limit not clamped", ctl_o, 2'b10);
    lps_in = 1;
    step();
    check("R11 high clears count", ctl_o, 2'b10);
    lps_in = 0;
    for (int i = 1; i <= LIM; i++) step();
    check("R11 limit again", d_o, 8'hFF);
    step();
    check("R11 clamp ctl", ctl_o, 0);
    check("R11 clamp d", d_o, 0);
    check("R11 clamp ready", rx_ready, 0);
    lreq_in = 1; stat_pend = 1; arb_won = 1;
    step();
    stat_pend = 0; arb_won = 0;
    check("R11 lreq blocked", lreq_fwd, 0);
    repeat (3) step();
    lps_in = 1;
    step();
    check("R12 released idle", ctl_o, 0);
    check("R13 lreq passes", lreq_fwd, 1);
    for (int i = 0; i < 3; i++) begin
      step();
      check("R12 dropped requests", ctl_o, 0);
    end
    lreq_in = 0;
    step();
    check("R13 lreq follows", lreq_fwd, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule